// File: doc/BRIEF.md
# Cross-Context Forward Pair Tracker

This block keeps the dependency records that arise when one thread context takes a register value straight from another context's uncommitted work: from a reorder-buffer entry still in flight, or off the result bus. Every granted forward becomes a pair record. The record holds the supplying (producer) entry, the receiving (consumer) entry and the register number. Each entry is named by its context number and its reorder-buffer tag. From these records the block keeps two flag vectors up to date. A forward flag marks each producer entry that has supplied a value to another thread. A read flag marks each consumer entry that still holds at least one unresolved pair.

The commit logic asks the block whether a given entry may retire. An entry whose read flag is set is held back. A pair retires in three cases: its producer commits, its consumer is squashed, or its producer is squashed. In the last case the value that was forwarded is wrong. The block then raises a flush request for the consumer's context one cycle later, naming the oldest affected consumer tag as the restart point. The reorder buffer squashes the younger entries, returns them to this block as ordinary squash events, and so a misspeculation spreads one context hop per cycle.

The pair store is small (16 records by default). When it is full, new forwards are refused and the consumer waits. Reorder-buffer storage, register files, restart PC lookup and the forwarding datapath lie outside the block.

Top module: `fwd_pair_tracker`

## Requirements
- R1: A forward request that is granted creates a pair. After the next rising edge, bit ctx*ROB_DEPTH+tag of `fwd_bits_o` is set for the producer entry and the same bit of `read_bits_o` is set for the consumer entry. ROB_DEPTH is a power of two.
- R2: `commit_block_o` equals the read bit of the entry named on the commit-check inputs, in the same cycle.
- R3: A consumer entry with several pairs keeps its read bit set until its last pair has retired.
- R4: A producer commit retires every pair of that producer. Its forward bit clears after the edge. Each affected consumer's read bit clears once that consumer has no pairs left.
- R5: A consumer squash retires every pair of that consumer and clears its read bit. A producer's forward bit stays set while it still has another pair.
- R6: A producer squash retires that producer's pairs. In the next cycle `flush_valid_o[c]` is high for each consumer context c, and slice c of `flush_tag_o` carries the consumer tag.
- R7: When one producer squash hits several consumers of the same context, the flush tag is the oldest of them. A lower tag is older.
- R8: With all pair slots in use, `fwd_grant_o` is low and a request changes no flag. One cycle after any pair retires, the grant is high again.
- R9: A forward request is refused in a cycle where the commit or squash event names the request's producer or consumer entry.
- R10: After reset all forward and read bits are zero, no flush is raised and the grant is high.
- R11: A flush request lasts one cycle per producer squash. Consumer squashes and commits raise no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fwd_req_i | input | 1 | A cross-context forward is attempted |
| fwd_prod_ctx_i | input | CTXW | Producer context |
| fwd_prod_tag_i | input | TAGW | Producer reorder-buffer tag |
| fwd_cons_ctx_i | input | CTXW | Consumer context |
| fwd_cons_tag_i | input | TAGW | Consumer reorder-buffer tag |
| fwd_reg_i | input | REGW | Forwarded register number |
| fwd_grant_o | output | 1 | The forward may proceed; a pair is recorded on the edge |
| pcommit_i | input | 1 | An entry commits |
| pcommit_ctx_i | input | CTXW | Context of the committing entry |
| pcommit_tag_i | input | TAGW | Tag of the committing entry |
| squash_i | input | 1 | An entry is squashed |
| squash_ctx_i | input | CTXW | Context of the squashed entry |
| squash_tag_i | input | TAGW | Tag of the squashed entry |
| ccheck_ctx_i | input | CTXW | Context of the entry asking to commit |
| ccheck_tag_i | input | TAGW | Tag of the entry asking to commit |
| commit_block_o | output | 1 | The queried entry must not commit |
| fwd_bits_o | output | NCTX*ROB_DEPTH | Forward flag per entry |
| read_bits_o | output | NCTX*ROB_DEPTH | Read flag per entry |
| flush_valid_o | output | NCTX | Flush request per consumer context |
| flush_tag_o | output | NCTX*TAGW | Restart tag per context, slice c for context c |

## Verification
The embedded properties watch, on every cycle, the invariants that hold for any traffic. A granted forward always sets both flags. A commit always clears that entry's forward flag and a consumer squash always clears its read flag. Every flush follows a squash. No reference count ever wraps, and no allocation happens into a full store. Other behaviours need a particular sequence of events to become visible, and only the bench scenarios show them: a read flag that survives the first of two retirements, a shared producer whose flag survives a squash of one of its consumers, choosing the oldest tag among several flushed consumers, refusal on a same-cycle conflict, and the grant coming back after a full store frees a slot.

// File: rtl/fwd_trk_pkg.sv
package fwd_trk_pkg;

  // Why a pair record leaves the store in a given cycle.
  typedef enum logic [1:0] {
    RET_NONE    = 2'd0,
    RET_PCOMMIT = 2'd1,
    RET_CSQUASH = 2'd2,
    RET_PSQUASH = 2'd3
  } retire_cause_e;

endpackage

// File: rtl/fpt_pair_table.sv
module fpt_pair_table #(
  parameter int PAIRS = 16,
  parameter int IDXW  = 6,
  parameter int REGW  = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic [IDXW-1:0]            alloc_prod_i,
  input  logic [IDXW-1:0]            alloc_cons_i,
  input  logic [REGW-1:0]            alloc_reg_i,
  input  logic [PAIRS-1:0]           retire_i,
  output logic [PAIRS-1:0]           valid_o,
  output logic [PAIRS-1:0][IDXW-1:0] prod_o,
  output logic [PAIRS-1:0][IDXW-1:0] cons_o,
  output logic                       has_free_o
);

  localparam int SLW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [PAIRS-1:0]           valid_q, valid_d;
  logic [PAIRS-1:0]           wr_en;
  logic [PAIRS-1:0][IDXW-1:0] prod_q, cons_q;
  logic [PAIRS-1:0][REGW-1:0] reg_q;
  logic [SLW-1:0]             slot;
  logic                       found;

  // Lowest free slot; a slot released this cycle is reused only next cycle.
  always_comb begin
    slot  = '0;
    found = 1'b0;
    for (int p = 0; p < PAIRS; p++) begin
      if (!found && !valid_q[p]) begin
        slot  = SLW'(p);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    valid_d = valid_q & ~retire_i;
    wr_en   = '0;
    if (alloc_i) begin
      valid_d[slot] = 1'b1;
      wr_en[slot]   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q[p] <= '0;
        cons_q[p] <= '0;
        reg_q[p]  <= '0;
      end else if (wr_en[p]) begin
        prod_q[p] <= alloc_prod_i;
        cons_q[p] <= alloc_cons_i;
        reg_q[p]  <= alloc_reg_i;
      end
    end

    // R1: one consumer operand is never recorded twice.
    p_unique_operand_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alloc_i && valid_q[p]) |-> !(cons_q[p] == alloc_cons_i && reg_q[p] == alloc_reg_i));
  end

  assign valid_o    = valid_q;
  assign prod_o     = prod_q;
  assign cons_o     = cons_q;
  assign has_free_o = found;

  p_alloc_has_room_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !(&valid_q));

endmodule

// File: rtl/fpt_ref_counts.sv
module fpt_ref_counts #(
  parameter int NENT  = 64,
  parameter int PAIRS = 16,
  parameter int IDXW  = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       inc_i,
  input  logic [IDXW-1:0]            inc_idx_i,
  input  logic [PAIRS-1:0][IDXW-1:0] pair_idx_i,
  input  logic [PAIRS-1:0]           drop_i,
  output logic [NENT-1:0]            nz_o
);

  localparam int CW = $clog2(PAIRS + 1);

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic [CW-1:0] cnt_q, cnt_d, dec;
    logic          inc_hit, upd;

    always_comb begin
      dec = '0;
      for (int p = 0; p < PAIRS; p++) begin
        if (drop_i[p] && pair_idx_i[p] == IDXW'(e)) dec = dec + CW'(1);
      end
      inc_hit = inc_i && (inc_idx_i == IDXW'(e));
      upd     = inc_hit || (dec != '0);
      cnt_d   = cnt_q + (inc_hit ? CW'(1) : CW'(0)) - dec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cnt_q <= '0;
      else if (upd) cnt_q <= cnt_d;
    end

    assign nz_o[e] = (cnt_q != '0);

    // R5: retirements never outnumber the pairs on record.
    p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, cnt_q} + {{CW{1'b0}}, inc_hit}) >= {1'b0, dec});
    // R8: a count never exceeds the store capacity.
    p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(inc_hit && dec == '0 && cnt_q == CW'(PAIRS)));
  end

endmodule

// File: rtl/fpt_flush_gen.sv
module fpt_flush_gen #(
  parameter int PAIRS = 16,
  parameter int NCTX  = 4,
  parameter int CTXW  = 2,
  parameter int TAGW  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [PAIRS-1:0]                hit_i,
  input  logic [PAIRS-1:0][CTXW+TAGW-1:0] cons_i,
  output logic [NCTX-1:0]                 valid_o,
  output logic [NCTX*TAGW-1:0]            tag_o
);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic            found;
    logic [TAGW-1:0] best;
    logic            vld_q;
    logic [TAGW-1:0] tag_q;

    // Oldest (lowest tag) consumer of this context among the hits.
    always_comb begin
      found = 1'b0;
      best  = '0;
      for (int p = 0; p < PAIRS; p++) begin
        if (hit_i[p] && cons_i[p][CTXW+TAGW-1:TAGW] == CTXW'(c) &&
            (!found || cons_i[p][TAGW-1:0] < best)) begin
          best  = cons_i[p][TAGW-1:0];
          found = 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= 1'b0;
      else         vld_q <= found;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    tag_q <= '0;
      else if (found) tag_q <= best;
    end

    assign valid_o[c]               = vld_q;
    assign tag_o[c*TAGW +: TAGW]    = tag_q;
  end

endmodule

// File: rtl/fwd_pair_tracker.sv
module fwd_pair_tracker
  import fwd_trk_pkg::*;
#(
  parameter int NCTX      = 4,
  parameter int ROB_DEPTH = 16,
  parameter int NREG      = 32,
  parameter int PAIRS     = 16,
  localparam int CTXW     = $clog2(NCTX),
  localparam int TAGW     = $clog2(ROB_DEPTH),
  localparam int REGW     = $clog2(NREG),
  localparam int IDXW     = CTXW + TAGW,
  localparam int NENT     = NCTX * ROB_DEPTH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fwd_req_i,
  input  logic [CTXW-1:0]      fwd_prod_ctx_i,
  input  logic [TAGW-1:0]      fwd_prod_tag_i,
  input  logic [CTXW-1:0]      fwd_cons_ctx_i,
  input  logic [TAGW-1:0]      fwd_cons_tag_i,
  input  logic [REGW-1:0]      fwd_reg_i,
  output logic                 fwd_grant_o,
  input  logic                 pcommit_i,
  input  logic [CTXW-1:0]      pcommit_ctx_i,
  input  logic [TAGW-1:0]      pcommit_tag_i,
  input  logic                 squash_i,
  input  logic [CTXW-1:0]      squash_ctx_i,
  input  logic [TAGW-1:0]      squash_tag_i,
  input  logic [CTXW-1:0]      ccheck_ctx_i,
  input  logic [TAGW-1:0]      ccheck_tag_i,
  output logic                 commit_block_o,
  output logic [NENT-1:0]      fwd_bits_o,
  output logic [NENT-1:0]      read_bits_o,
  output logic [NCTX-1:0]      flush_valid_o,
  output logic [NCTX*TAGW-1:0] flush_tag_o
);

  logic [IDXW-1:0] fp_idx, fc_idx, pc_idx, sq_idx, ck_idx;
  assign fp_idx = {fwd_prod_ctx_i, fwd_prod_tag_i};
  assign fc_idx = {fwd_cons_ctx_i, fwd_cons_tag_i};
  assign pc_idx = {pcommit_ctx_i, pcommit_tag_i};
  assign sq_idx = {squash_ctx_i, squash_tag_i};
  assign ck_idx = {ccheck_ctx_i, ccheck_tag_i};

  logic [PAIRS-1:0]           pv;
  logic [PAIRS-1:0][IDXW-1:0] pprod, pcons;
  logic                       has_free;
  retire_cause_e              cause [PAIRS];
  logic [PAIRS-1:0]           retire, psq_hit;
  logic                       conflict, alloc;

  // Per-pair retirement: a consumer squash wins over a producer squash,
  // since the consumer is leaving anyway and needs no flush.
  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      cause[p] = RET_NONE;
      if (pv[p]) begin
        if (squash_i && pcons[p] == sq_idx)       cause[p] = RET_CSQUASH;
        else if (squash_i && pprod[p] == sq_idx)  cause[p] = RET_PSQUASH;
        else if (pcommit_i && pprod[p] == pc_idx) cause[p] = RET_PCOMMIT;
      end
      retire[p]  = (cause[p] != RET_NONE);
      psq_hit[p] = (cause[p] == RET_PSQUASH);
    end
  end

  always_comb begin
    conflict = (pcommit_i && (pc_idx == fp_idx || pc_idx == fc_idx)) ||
               (squash_i  && (sq_idx == fp_idx || sq_idx == fc_idx));
    fwd_grant_o = has_free && !conflict;
    alloc       = fwd_req_i && fwd_grant_o;
  end

  fpt_pair_table #(.PAIRS(PAIRS), .IDXW(IDXW), .REGW(REGW)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (alloc),
    .alloc_prod_i (fp_idx),
    .alloc_cons_i (fc_idx),
    .alloc_reg_i  (fwd_reg_i),
    .retire_i     (retire),
    .valid_o      (pv),
    .prod_o       (pprod),
    .cons_o       (pcons),
    .has_free_o   (has_free)
  );

  fpt_ref_counts #(.NENT(NENT), .PAIRS(PAIRS), .IDXW(IDXW)) u_prod_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (alloc),
    .inc_idx_i  (fp_idx),
    .pair_idx_i (pprod),
    .drop_i     (retire),
    .nz_o       (fwd_bits_o)
  );

  fpt_ref_counts #(.NENT(NENT), .PAIRS(PAIRS), .IDXW(IDXW)) u_cons_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (alloc),
    .inc_idx_i  (fc_idx),
    .pair_idx_i (pcons),
    .drop_i     (retire),
    .nz_o       (read_bits_o)
  );

  fpt_flush_gen #(.PAIRS(PAIRS), .NCTX(NCTX), .CTXW(CTXW), .TAGW(TAGW)) u_flush (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (psq_hit),
    .cons_i  (pcons),
    .valid_o (flush_valid_o),
    .tag_o   (flush_tag_o)
  );

  assign commit_block_o = read_bits_o[ck_idx];

  p_fwd_sets_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> (fwd_bits_o[$past(fp_idx)] && read_bits_o[$past(fc_idx)]));

  p_commit_clears_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcommit_i |=> !fwd_bits_o[$past(pc_idx)]);

  p_csquash_clears_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> !read_bits_o[$past(sq_idx)]);

  p_flush_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flush_valid_o) |-> $past(squash_i));

endmodule

// File: tb/fwd_pair_tracker_tb_top.sv
module fwd_pair_tracker_tb_top;

  localparam int NCTX = 4;
  localparam int TAGW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fwd_req = 1'b0;
  logic [1:0]  fpc = '0, fcc = '0, pcc = '0, sqc = '0, ckc = '0;
  logic [3:0]  fpt = '0, fct = '0, pct = '0, sqt = '0, ckt = '0;
  logic [4:0]  freg = '0;
  logic        pcommit = 1'b0, squash = 1'b0;
  logic        grant, cblock;
  logic [63:0] fbits, rbits;
  logic [3:0]  fvalid;
  logic [15:0] ftag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fwd_pair_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fwd_req_i(fwd_req), .fwd_prod_ctx_i(fpc), .fwd_prod_tag_i(fpt),
    .fwd_cons_ctx_i(fcc), .fwd_cons_tag_i(fct), .fwd_reg_i(freg),
    .fwd_grant_o(grant),
    .pcommit_i(pcommit), .pcommit_ctx_i(pcc), .pcommit_tag_i(pct),
    .squash_i(squash), .squash_ctx_i(sqc), .squash_tag_i(sqt),
    .ccheck_ctx_i(ckc), .ccheck_tag_i(ckt), .commit_block_o(cblock),
    .fwd_bits_o(fbits), .read_bits_o(rbits),
    .flush_valid_o(fvalid), .flush_tag_o(ftag)
  );

  // op: 0 idle, 1 forward a->b, 2 commit a, 3 squash b,
  //     4 forward plus commit a, 5 forward plus squash b, 6 squash a
  typedef struct packed {
    logic [2:0] op;
    logic [1:0] ac; logic [3:0] at;
    logic [1:0] bc; logic [3:0] bt;
    logic [4:0] rg;
    logic       eg, ef, er;
    logic [3:0] efl;
    logic [3:0] eft;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    {3'd1, 2'd0, 4'd2, 2'd1, 4'd5, 5'd3, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd1, 2'd0, 4'd3, 2'd1, 4'd5, 5'd4, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd2, 2'd0, 4'd2, 2'd1, 4'd5, 5'd0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd0},
    {3'd2, 2'd0, 4'd3, 2'd1, 4'd5, 5'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    {3'd1, 2'd2, 4'd1, 2'd3, 4'd7, 5'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd1, 2'd2, 4'd4, 2'd3, 4'd7, 5'd2, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd3, 2'd2, 4'd1, 2'd3, 4'd7, 5'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    {3'd1, 2'd0, 4'd1, 2'd2, 4'd6, 5'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd1, 2'd0, 4'd1, 2'd3, 4'd9, 5'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd3, 2'd0, 4'd1, 2'd2, 4'd6, 5'd0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0},
    {3'd6, 2'd0, 4'd1, 2'd3, 4'd9, 5'd0, 1'b0, 1'b0, 1'b0, 4'd8, 4'd9},
    {3'd0, 2'd0, 4'd1, 2'd3, 4'd9, 5'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    {3'd1, 2'd1, 4'd0, 2'd2, 4'd8, 5'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd1, 2'd1, 4'd0, 2'd2, 4'd3, 5'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd1, 2'd1, 4'd0, 2'd3, 4'd2, 5'd1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0},
    {3'd6, 2'd1, 4'd0, 2'd2, 4'd3, 5'd0, 1'b0, 1'b0, 1'b0, 4'd12, 4'd3},
    {3'd4, 2'd0, 4'd5, 2'd1, 4'd1, 5'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0},
    {3'd5, 2'd0, 4'd6, 2'd1, 4'd1, 5'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0}
  };

  function automatic string tag_of(int i);
    case (i)
      2:       return "R3";
      3:       return "R4";
      6, 9:    return "R5";
      10:      return "R6";
      11:      return "R11";
      15:      return "R7";
      16, 17:  return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fwd_req = 1'b0; pcommit = 1'b0; squash = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R10: reset state
    chk(fbits == '0, "R10", int'(fbits != '0), 0);
    chk(rbits == '0, "R10", int'(rbits != '0), 0);
    chk(fvalid == '0, "R10", int'(fvalid), 0);
    chk(grant == 1'b1, "R10", int'(grant), 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      fpc = v.ac; fpt = v.at; fcc = v.bc; fct = v.bt; freg = v.rg;
      ckc = v.bc; ckt = v.bt;
      fwd_req = (v.op == 3'd1 || v.op == 3'd4 || v.op == 3'd5);
      pcommit = (v.op == 3'd2 || v.op == 3'd4);
      pcc = v.ac; pct = v.at;
      squash = (v.op == 3'd3 || v.op == 3'd5 || v.op == 3'd6);
      sqc = (v.op == 3'd6) ? v.ac : v.bc;
      sqt = (v.op == 3'd6) ? v.at : v.bt;
      #1;
      if (fwd_req) chk(grant == v.eg, tag_of(i), int'(grant), int'(v.eg));
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      #1;
      chk(fbits[{v.ac, v.at}] == v.ef, tag_of(i), int'(fbits[{v.ac, v.at}]), int'(v.ef));
      chk(rbits[{v.bc, v.bt}] == v.er, tag_of(i), int'(rbits[{v.bc, v.bt}]), int'(v.er));
      chk(cblock == v.er, "R2", int'(cblock), int'(v.er));
      chk(fvalid == v.efl, tag_of(i), int'(fvalid), int'(v.efl));
      if (v.efl[v.bc])
        chk(ftag[v.bc*TAGW +: TAGW] == v.eft, tag_of(i),
            int'(ftag[v.bc*TAGW +: TAGW]), int'(v.eft));
    end

    // R8: fill every slot, then one more request is refused
    for (int k = 0; k < 16; k++) begin
      fpc = 2'd0; fpt = 4'(k); fcc = 2'd1; fct = 4'(k); freg = 5'd0;
      fwd_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    fpc = 2'd2; fpt = 4'd0; fcc = 2'd3; fct = 4'd0; ckc = 2'd3; ckt = 4'd0;
    fwd_req = 1'b1;
    #1;
    chk(grant == 1'b0, "R8", int'(grant), 0);
    @(posedge clk);
    @(negedge clk);
    fwd_req = 1'b0;
    #1;
    chk(rbits[{2'd3, 4'd0}] == 1'b0, "R8", int'(rbits[{2'd3, 4'd0}]), 0);
    chk(fbits[{2'd2, 4'd0}] == 1'b0, "R8", int'(fbits[{2'd2, 4'd0}]), 0);
    chk(rbits[{2'd1, 4'd15}] == 1'b1, "R8", int'(rbits[{2'd1, 4'd15}]), 1);
    pcommit = 1'b1; pcc = 2'd0; pct = 4'd0;
    @(posedge clk);
    @(negedge clk);
    pcommit = 1'b0;
    #1;
    chk(grant == 1'b1, "R8", int'(grant), 1);
    chk(rbits[{2'd1, 4'd0}] == 1'b0, "R4", int'(rbits[{2'd1, 4'd0}]), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule